// File: doc/BRIEF.md
# Indirect SDRAM Configuration Register File

This block holds the configuration and status registers of a four-bank SDRAM controller. A register bus sees only two locations: an index register and a data window. Software writes the number of an internal register into the index register; reads and writes of the data window then reach that internal register. Each stored field is masked on write. Error registers are cleared by writing ones. Changes of the enable and self-refresh style control bits leave a mark in a read-only status register.

Each bank register is decoded into three things: a base address, a power-of-two size and a valid bit. While the controller is enabled, the block compares an incoming memory address against every bank and reports a one-hot hit vector. An ECC error status register drives an interrupt line. Command sequencing, refresh timing and the ECC datapath belong to other blocks.

Top module: `sdram_cfg_regs`

## Requirements
- R1: Bus offset 0x10 is the index register. Writes store all 32 bits, and a read returns them. Bus offset 0x11 is the data window onto the internal register selected by the index. Any other bus offset reads 0 and ignores writes.
- R2: A read request yields `bus_rdata_o` with `bus_rvalid_o` high for exactly one cycle, in the cycle after the request.
- R3: Reset values: config (index 0x20) 0x00800000, refresh (0x30) 0x05F00000, power timer (0x34) 0x07C00000, timing (0x80) 0x00854009. Every other register resets to 0.
- R4: Write masks: config 0xFFE00000, refresh 0x3FF80000, timing 0x018FC01F, ECC config (0x94) 0xFFF00000 & 0x00F00000 = 0x00F00000, ECC error status (0x98) 0xFFF0F000, bank configs (0x40, 0x44, 0x48, 0x4C for banks 0 to 3) 0xFFDEE001. The error address register (0x10) stores all bits.
- R5: Reads of the timing register and of any unmapped index return 0xFFFFFFFF. Writes to status (0x24) are ignored.
- R6: A power timer write stores bits 31:27 of the data and forces bits 26:22 to ones (value 0x07C00000).
- R7: The error status registers at 0x00 and 0x08 are write-1-to-clear.
- R8: When config bit 31 (enable) goes from 0 to 1, status bit 31 is cleared. When it goes from 1 to 0, status bit 31 is set.
- R9: When config bit 30 rises, status bit 30 is set. When it falls, status bit 30 is cleared.
- R10: `ecc_irq_o` is high exactly while the ECC error status register is nonzero.
- R11: Bank field layout: base in bits 31:23, size code in bits 19:17, valid in bit 0. The size is 4 MiB << code, and code 7 is invalid. Bank n hits when all of these hold: the controller is enabled, the bank is valid, the code is not 7, and the address lies in [base, base+size).
- R12: `bank_hit_o` is one-hot or zero. When several banks hit, bit n of the lowest-numbered hitting bank is set.
- R13: A bank-config write changes the decode from the cycle after the write, never in the write cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register bus request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 10 | Register bus offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after request |
| bus_rvalid_o | output | 1 | Read data valid |
| mem_addr_i | input | 32 | Address to decode against the banks |
| bank_hit_o | output | 4 | One-hot hitting bank |
| ecc_irq_o | output | 1 | ECC error interrupt |

## Verification
Two functions can fall in the same cycle: a bank-config write and the address decode that depends on it. The same is true of a config write that flips the enable bit while an address is being decoded. The bench holds a memory address steady and issues the bank write in the same cycle. It samples `bank_hit_o` before the clock edge that commits the write and again after it. The old mapping must hold in the first sample and the new mapping in the second. Overlapping banks are programmed on purpose to judge the lowest-bank priority at the range edges.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;
  localparam int unsigned DW = 32;

  localparam logic [DW-1:0] IDX_ERR0   = 32'h00;
  localparam logic [DW-1:0] IDX_ERR1   = 32'h08;
  localparam logic [DW-1:0] IDX_EADDR  = 32'h10;
  localparam logic [DW-1:0] IDX_CFG    = 32'h20;
  localparam logic [DW-1:0] IDX_STAT   = 32'h24;
  localparam logic [DW-1:0] IDX_RFSH   = 32'h30;
  localparam logic [DW-1:0] IDX_PWR    = 32'h34;
  localparam logic [DW-1:0] IDX_BANK0  = 32'h40;
  localparam logic [DW-1:0] IDX_TIMING = 32'h80;
  localparam logic [DW-1:0] IDX_ECCCFG = 32'h94;
  localparam logic [DW-1:0] IDX_ECCERR = 32'h98;

  localparam logic [DW-1:0] MSK_CFG    = 32'hFFE0_0000;
  localparam logic [DW-1:0] MSK_RFSH   = 32'h3FF8_0000;
  localparam logic [DW-1:0] MSK_TIMING = 32'h018F_C01F;
  localparam logic [DW-1:0] MSK_ECCCFG = 32'h00F0_0000;
  localparam logic [DW-1:0] MSK_ECCERR = 32'hFFF0_F000;
  localparam logic [DW-1:0] MSK_BANK   = 32'hFFDE_E001;
  localparam logic [DW-1:0] MSK_PWR    = 32'hF800_0000;
  localparam logic [DW-1:0] PWR_FORCE  = 32'h07C0_0000;

  localparam logic [DW-1:0] RST_CFG    = 32'h0080_0000;
  localparam logic [DW-1:0] RST_RFSH   = 32'h05F0_0000;
  localparam logic [DW-1:0] RST_PWR    = 32'h07C0_0000;
  localparam logic [DW-1:0] RST_TIMING = 32'h0085_4009;

  localparam int unsigned CFG_EN_BIT = 31;
  localparam int unsigned CFG_SR_BIT = 30;
  localparam int unsigned SIZE_LSB   = 17;
  localparam int unsigned BASE_LSB   = 23;
  localparam int unsigned MIN_SHIFT  = 22;
endpackage

// File: rtl/sdram_bank_dec.sv
module sdram_bank_dec
  import sdram_cfg_pkg::*;
(
  input  logic [DW-1:0] bcr_i,
  input  logic          en_i,
  input  logic [DW-1:0] addr_i,
  output logic          hit_o
);
  logic [2:0]  code;
  logic [DW:0] base, lim, a_ext;

  always_comb begin
    code  = bcr_i[SIZE_LSB+2:SIZE_LSB];
    base  = {1'b0, bcr_i[DW-1:BASE_LSB], {BASE_LSB{1'b0}}};
    lim   = base + ((DW+1)'(1) << (MIN_SHIFT + 32'(code)));
    a_ext = {1'b0, addr_i};
    hit_o = en_i && bcr_i[0] && (code != 3'd7) && (a_ext >= base) && (a_ext < lim);
  end
endmodule

// File: rtl/sdram_hit_prio.sv
module sdram_hit_prio #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] hit_i,
  output logic [N-1:0] sel_o
);
  logic found;
  always_comb begin
    sel_o = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hit_i[i] && !found) begin
        sel_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdram_cfg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BUS_AW    = 10,
  parameter logic [BUS_AW-1:0] IDX_OFS = 10'h010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              bus_rvalid_o,
  input  logic [DW-1:0]     mem_addr_i,
  output logic [NUM_BANKS-1:0] bank_hit_o,
  output logic              ecc_irq_o
);
  localparam logic [BUS_AW-1:0] DAT_OFS = IDX_OFS + BUS_AW'(1);

  logic [DW-1:0] addr_q, err0_q, err1_q, eaddr_q, cfg_q, stat_q;
  logic [DW-1:0] rfsh_q, pwr_q, timing_q, ecccfg_q, eccerr_q;
  logic [DW-1:0] bcr_q [NUM_BANKS];
  logic [DW-1:0] rd_val, cfg_nv, rdata_q;
  logic          rvalid_q;
  logic          wr_idx, wr_dat, rd_req;
  logic [NUM_BANKS-1:0] raw_hit;

  assign wr_idx = bus_req_i && bus_we_i && (bus_addr_i == IDX_OFS);
  assign wr_dat = bus_req_i && bus_we_i && (bus_addr_i == DAT_OFS);
  assign rd_req = bus_req_i && !bus_we_i;
  assign cfg_nv = bus_wdata_i & MSK_CFG;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      err0_q   <= '0;
      err1_q   <= '0;
      eaddr_q  <= '0;
      cfg_q    <= RST_CFG;
      stat_q   <= '0;
      rfsh_q   <= RST_RFSH;
      pwr_q    <= RST_PWR;
      timing_q <= RST_TIMING;
      ecccfg_q <= '0;
      eccerr_q <= '0;
      for (int b = 0; b < NUM_BANKS; b++) bcr_q[b] <= '0;
    end else if (wr_idx) begin
      addr_q <= bus_wdata_i;
    end else if (wr_dat) begin
      unique case (addr_q)
        IDX_ERR0:   err0_q   <= err0_q & ~bus_wdata_i;
        IDX_ERR1:   err1_q   <= err1_q & ~bus_wdata_i;
        IDX_EADDR:  eaddr_q  <= bus_wdata_i;
        IDX_CFG: begin
          if (!cfg_q[CFG_EN_BIT] && cfg_nv[CFG_EN_BIT])      stat_q[CFG_EN_BIT] <= 1'b0;
          else if (cfg_q[CFG_EN_BIT] && !cfg_nv[CFG_EN_BIT]) stat_q[CFG_EN_BIT] <= 1'b1;
          if (!cfg_q[CFG_SR_BIT] && cfg_nv[CFG_SR_BIT])      stat_q[CFG_SR_BIT] <= 1'b1;
          else if (cfg_q[CFG_SR_BIT] && !cfg_nv[CFG_SR_BIT]) stat_q[CFG_SR_BIT] <= 1'b0;
          cfg_q <= cfg_nv;
        end
        IDX_RFSH:   rfsh_q   <= bus_wdata_i & MSK_RFSH;
        IDX_PWR:    pwr_q    <= (bus_wdata_i & MSK_PWR) | PWR_FORCE;
        IDX_TIMING: timing_q <= bus_wdata_i & MSK_TIMING;
        IDX_ECCCFG: ecccfg_q <= bus_wdata_i & MSK_ECCCFG;
        IDX_ECCERR: eccerr_q <= bus_wdata_i & MSK_ECCERR;
        default: begin
          for (int b = 0; b < NUM_BANKS; b++)
            if (addr_q == IDX_BANK0 + DW'(4 * b)) bcr_q[b] <= bus_wdata_i & MSK_BANK;
        end
      endcase
    end
  end

  // data-window read mux; timing and holes read as all ones
  always_comb begin
    rd_val = '1;
    unique case (addr_q)
      IDX_ERR0:   rd_val = err0_q;
      IDX_ERR1:   rd_val = err1_q;
      IDX_EADDR:  rd_val = eaddr_q;
      IDX_CFG:    rd_val = cfg_q;
      IDX_STAT:   rd_val = stat_q;
      IDX_RFSH:   rd_val = rfsh_q;
      IDX_PWR:    rd_val = pwr_q;
      IDX_ECCCFG: rd_val = ecccfg_q;
      IDX_ECCERR: rd_val = eccerr_q;
      default: begin
        for (int b = 0; b < NUM_BANKS; b++)
          if (addr_q == IDX_BANK0 + DW'(4 * b)) rd_val = bcr_q[b];
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) begin
        if (bus_addr_i == IDX_OFS)      rdata_q <= addr_q;
        else if (bus_addr_i == DAT_OFS) rdata_q <= rd_val;
        else                            rdata_q <= '0;
      end
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;
  assign ecc_irq_o    = |eccerr_q;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdram_bank_dec u_dec (
      .bcr_i (bcr_q[g]),
      .en_i  (cfg_q[CFG_EN_BIT]),
      .addr_i(mem_addr_i),
      .hit_o (raw_hit[g])
    );
  end

  sdram_hit_prio #(.N(NUM_BANKS)) u_prio (
    .hit_i(raw_hit),
    .sel_o(bank_hit_o)
  );
endmodule

// File: rtl/sdram_cfg_chk.sv
module sdram_cfg_chk
  import sdram_cfg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BUS_AW    = 10,
  parameter logic [BUS_AW-1:0] IDX_OFS = 10'h010
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [BUS_AW-1:0] bus_addr_i,
  input logic [DW-1:0]     bus_wdata_i,
  input logic              bus_rvalid_o,
  input logic [NUM_BANKS-1:0] bank_hit_o,
  input logic              ecc_irq_o,
  input logic [DW-1:0]     addr_q,
  input logic [DW-1:0]     cfg_q,
  input logic [DW-1:0]     stat_q,
  input logic [DW-1:0]     pwr_q
);
  logic dat_wr;
  assign dat_wr = bus_req_i && bus_we_i && (bus_addr_i == IDX_OFS + BUS_AW'(1));

  a_r2_rvalid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i) |=> bus_rvalid_o);
  a_r2_rvalid_only_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_i && !bus_we_i) |=> !bus_rvalid_o);
  a_r5_status_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr && addr_q == IDX_STAT) |=> $stable(stat_q));
  a_r6_pwr_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_q[26:22] == 5'h1F);
  a_r8_en_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr && addr_q == IDX_CFG && !cfg_q[31] && bus_wdata_i[31]) |=> !stat_q[31]);
  a_r8_en_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr && addr_q == IDX_CFG && cfg_q[31] && !bus_wdata_i[31]) |=> stat_q[31]);
  a_r10_irq_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr && addr_q == IDX_ECCERR && ((bus_wdata_i & MSK_ECCERR) != '0)) |=> ecc_irq_o);
  a_r10_irq_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr && addr_q == IDX_ECCERR && ((bus_wdata_i & MSK_ECCERR) == '0)) |=> !ecc_irq_o);
  a_r11_hit_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bank_hit_o) |-> cfg_q[31]);
  a_r12_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_hit_o));
endmodule

bind sdram_cfg_regs sdram_cfg_chk #(
  .NUM_BANKS(NUM_BANKS), .BUS_AW(BUS_AW), .IDX_OFS(IDX_OFS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rvalid_o(bus_rvalid_o),
  .bank_hit_o(bank_hit_o), .ecc_irq_o(ecc_irq_o), .addr_q(addr_q), .cfg_q(cfg_q),
  .stat_q(stat_q), .pwr_q(pwr_q)
);

// File: tb/sdram_cfg_regs_bench.sv
module sdram_cfg_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [9:0]  baddr = '0;
  logic [31:0] wdata = '0, rdata, maddr = '0;
  logic        rvalid, irq;
  logic [3:0]  hit;
  int checks = 0, fails = 0;

  localparam logic [9:0] OFS_IDX = 10'h010;
  localparam logic [9:0] OFS_DAT = 10'h011;

  always #10 clk = ~clk;

  sdram_cfg_regs u_sdram_cfg_regs (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(baddr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_rvalid_o(rvalid),
    .mem_addr_i(maddr), .bank_hit_o(hit), .ecc_irq_o(irq)
  );

  // {index, write data, expected readback}
  localparam logic [95:0] VEC [12] = '{
    {32'h30, 32'hFFFF_FFFF, 32'h3FF8_0000},
    {32'h34, 32'hFFFF_FFFF, 32'hFFC0_0000},
    {32'h34, 32'h0000_0000, 32'h07C0_0000},
    {32'h80, 32'h1234_5678, 32'hFFFF_FFFF},
    {32'h94, 32'hFFFF_FFFF, 32'h00F0_0000},
    {32'h10, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {32'h00, 32'hFFFF_FFFF, 32'h0000_0000},
    {32'h08, 32'h0000_1234, 32'h0000_0000},
    {32'h44, 32'hFFFF_FFFF, 32'hFFDE_E001},
    {32'h44, 32'h0000_0000, 32'h0000_0000},
    {32'h60, 32'h0000_0055, 32'hFFFF_FFFF},
    {32'h24, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; baddr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; baddr = a;
    @(negedge clk); req = 1'b0;
    chk("R2 rvalid", {31'b0, rvalid}, 32'd1);
    d = rdata;
  endtask

  task automatic reg_wr(input logic [31:0] idx, input logic [31:0] d);
    bus_wr(OFS_IDX, idx); bus_wr(OFS_DAT, d);
  endtask

  task automatic reg_chk(input string req_tag, input logic [31:0] idx, input logic [31:0] exp);
    logic [31:0] v;
    bus_wr(OFS_IDX, idx); bus_rd(OFS_DAT, v); chk(req_tag, v, exp);
  endtask

  task automatic hit_chk(input string req_tag, input logic [31:0] a, input logic [3:0] exp);
    @(negedge clk); maddr = a; #1;
    chk(req_tag, {28'b0, hit}, {28'b0, exp});
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 reset state
    chk("R3 rvalid", {31'b0, rvalid}, 32'd0);
    chk("R3 irq", {31'b0, irq}, 32'd0);
    reg_chk("R3 cfg", 32'h20, 32'h0080_0000);
    reg_chk("R3 rfsh", 32'h30, 32'h05F0_0000);
    reg_chk("R3 pwr", 32'h34, 32'h07C0_0000);
    reg_chk("R3 stat", 32'h24, 32'h0);
    reg_chk("R3 bank0", 32'h40, 32'h0);
    // R1 index readback, foreign offset
    bus_wr(OFS_IDX, 32'hA5A5_0030);
    bus_rd(OFS_IDX, v); chk("R1 index", v, 32'hA5A5_0030);
    bus_wr(10'h012, 32'h0000_0020);
    bus_rd(OFS_IDX, v); chk("R1 foreign write", v, 32'hA5A5_0030);
    bus_rd(10'h012, v); chk("R1 foreign read", v, 32'h0);

    // R4 R5 R6 R7 table
    for (int i = 0; i < 12; i++) begin
      reg_wr(VEC[i][95:64], VEC[i][63:32]);
      reg_chk("R4/R5/R6/R7 vector", VEC[i][95:64], VEC[i][31:0]);
    end

    // R8 R9 enable/self-refresh edges
    reg_wr(32'h20, 32'hC000_0000);
    reg_chk("R9 rise", 32'h24, 32'h4000_0000);
    reg_wr(32'h20, 32'h0000_0000);
    reg_chk("R8 fall", 32'h24, 32'h8000_0000);
    reg_wr(32'h20, 32'h801F_FFFF);
    reg_chk("R8 rise", 32'h24, 32'h0);
    reg_chk("R4 cfg mask", 32'h20, 32'h8000_0000);

    // R10 interrupt
    reg_wr(32'h98, 32'h0000_0F00);
    chk("R10 masked", {31'b0, irq}, 32'd0);
    reg_wr(32'h98, 32'h0000_1000);
    chk("R10 raise", {31'b0, irq}, 32'd1);
    reg_chk("R4 eccerr", 32'h98, 32'h0000_1000);
    reg_wr(32'h98, 32'h0);
    chk("R10 drop", {31'b0, irq}, 32'd0);

    // R11 R12 decode
    reg_wr(32'h40, 32'h0002_0001);
    reg_wr(32'h44, 32'h0080_0001);
    reg_wr(32'h48, 32'h0004_0001);
    reg_wr(32'h4C, 32'h100E_0001);
    hit_chk("R12 overlap low", 32'h0000_0000, 4'b0001);
    hit_chk("R11 bank0 top", 32'h007F_FFFF, 4'b0001);
    hit_chk("R12 bank1 over 2", 32'h0080_0000, 4'b0010);
    hit_chk("R11 bank1 top", 32'h00BF_FFFF, 4'b0010);
    hit_chk("R11 bank2 only", 32'h00C0_0000, 4'b0100);
    hit_chk("R11 bank2 top", 32'h00FF_FFFF, 4'b0100);
    hit_chk("R11 past all", 32'h0100_0000, 4'b0000);
    hit_chk("R11 code7", 32'h1000_0000, 4'b0000);
    reg_wr(32'h20, 32'h0);
    hit_chk("R11 disabled", 32'h0000_0000, 4'b0000);
    reg_wr(32'h20, 32'h8000_0000);

    // R13 same-cycle write and decode
    bus_wr(OFS_IDX, 32'h4C);
    @(negedge clk); maddr = 32'h2000_0000; req = 1'b1; we = 1'b1; baddr = OFS_DAT;
    wdata = 32'h2000_0001; #1;
    chk("R13 old map", {28'b0, hit}, 32'h0);
    @(negedge clk); req = 1'b0; we = 1'b0; #1;
    chk("R13 new map", {28'b0, hit}, 32'h8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule